// File: doc/BRIEF.md
# Wide-Integer Add/Subtract Coprocessor

This block adds or subtracts two 1024-bit unsigned integers on behalf of a host processor. The host sends short commands over a narrow command port. Each command carries an operation code and one memory address. The block moves all operand and result data itself, acting as a master on a memory-mapped bus of parameterised width. It reads each operand as a series of bus words into one of two local operand registers. It writes the result, one bus word at a time, to the address the host named. No data is returned on the command port. The command port reports only completion and a final carry/borrow flag.

The two operand registers keep their contents between commands. The host can therefore issue several arithmetic commands on the same operands, or reload only one of them, without paying again for the long fetch. The arithmetic runs on one bus-width slice per beat. A carry or borrow is chained between slices and is folded into the write-back beats, so no full-width adder is built.

Top module: `wop_accel`

## Requirements
- R1: While reset is held and right after it, the command port is ready, no read or write is asserted on the master port, the completion pulse is low and the carry flag reads 0.
- R2: A load command (op code 2'b00 fills operand X, 2'b01 fills operand Y) issues OP_W/BUS_W reads. The byte addresses are base, base+BUS_W/8, and so on, in ascending order. The word read on the first beat becomes the least significant word of the operand.
- R3: While the bus stalls a transfer with waitrequest high, the block keeps asserting the same read or write, with the address and write data unchanged.
- R4: Op code 2'b10 writes (X+Y) mod 2^OP_W as OP_W/BUS_W writes to ascending byte addresses from the destination, least significant word first. The carry flag then holds the carry out of the top bit.
- R5: Op code 2'b11 writes (X−Y) mod 2^OP_W in the same beat order as R4. The carry flag then reads 1 exactly when X < Y as unsigned numbers, and 0 otherwise (including X == Y).
- R6: From the cycle a command is accepted until its final beat is accepted, the command port is not ready. Commands presented in that window cause no bus transfer and no change to either operand.
- R7: The completion output pulses high for exactly one cycle. That cycle is the one after the last bus beat of the command is accepted. The carry flag changes only together with this pulse.
- R8: The operand registers keep their contents across commands. An arithmetic command issues no reads, and loading one operand leaves the other unchanged.
- R9: The master port never asserts read and write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block idle; command accepted when both high |
| cmd_op | input | 2 | 00 load X, 01 load Y, 10 add, 11 subtract |
| cmd_addr | input | ADDR_W | Operand source or result destination byte address |
| cmd_done | output | 1 | One-cycle completion pulse |
| carry_flag | output | 1 | Carry (add) or borrow (subtract) of the last arithmetic command |
| mem_address | output | ADDR_W | Master byte address |
| mem_read | output | 1 | Master read request |
| mem_write | output | 1 | Master write request |
| mem_writedata | output | BUS_W | Master write data |
| mem_readdata | input | BUS_W | Read data, valid in the cycle a read is accepted |
| mem_waitrequest | input | 1 | Slave stall; transfer accepted when low |

## Verification
The assertions assume that the bus slave returns read data in the same cycle it drops waitrequest. They also assume the host only relies on a command being taken when cmd_ready is high. The bench's memory model answers reads from a word array in zero cycles and drives waitrequest from a seeded random stream, with one phase that has no stalls. Commands go in only at a falling edge where cmd_ready is high. Commands deliberately presented while busy are held for a few cycles only and are withdrawn well before the running command can finish.

// File: rtl/wop_pkg.sv
`timescale 1ns/1ps
// Shared types for the wide-operand coprocessor: command codes and
// controller states. Assumes a two-bit opcode field on the command port.
package wop_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_X = 2'b00,
        OP_LOAD_Y = 2'b01,
        OP_ADD    = 2'b10,
        OP_SUB    = 2'b11
    } wop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_STORE = 2'b10
    } wop_state_e;
endpackage

// File: rtl/wop_operand_store.sv
`timescale 1ns/1ps
// Two operand registers, each held as BEATS slices of BUS_W bits.
// Writes go to one slice of one operand per cycle. Both operands are
// read back at the same slice index. Assumes BEATS is a power of two.
module wop_operand_store #(
    parameter int BUS_W = 64,
    parameter int BEATS = 16,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel_y,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] x_slice,
    output logic [BUS_W-1:0] y_slice
);
    logic [BUS_W-1:0] x_mem [BEATS];
    logic [BUS_W-1:0] y_mem [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        // Capture one fetched bus word into the addressed slice
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x_mem[g] <= '0;
                y_mem[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                if (wr_sel_y) y_mem[g] <= wr_data;
                else          x_mem[g] <= wr_data;
            end
        end
    end

    // Present the current slice of both operands to the arithmetic
    always_comb begin
        x_slice = x_mem[idx];
        y_slice = y_mem[idx];
    end
endmodule

// File: rtl/wop_slice_alu.sv
`timescale 1ns/1ps
// One BUS_W-bit slice of a ripple add/subtract. Subtraction inverts the
// second operand; the caller seeds the chain with carry-in 1 for subtract.
module wop_slice_alu #(
    parameter int BUS_W = 64
) (
    input  logic             do_sub,
    input  logic             cin,
    input  logic [BUS_W-1:0] a,
    input  logic [BUS_W-1:0] b,
    output logic [BUS_W-1:0] sum,
    output logic             cout
);
    // Form slice sum and carry out
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, (do_sub ? ~b : b)} + {{BUS_W{1'b0}}, cin};
    end
endmodule

// File: rtl/wop_ctrl.sv
`timescale 1ns/1ps
// Command sequencer: accepts a command when idle, then steps through
// BEATS bus beats, advancing only when waitrequest is low. It holds the
// slice carry between write beats and records the final flag.
module wop_ctrl
    import wop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 64,
    parameter int BEATS  = 16,
    parameter int IDX_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic              carry_flag,
    input  logic              waitrequest,
    output logic              mem_read,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_address,
    output logic [IDX_W-1:0]  beat,
    output logic              load_en,
    output logic              sel_y,
    output logic              do_sub,
    output logic              carry_q,
    input  logic              alu_cout
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(BUS_W / 8);
    localparam logic [IDX_W-1:0]  LAST  = IDX_W'(BEATS - 1);

    wop_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              flag_q;
    logic              last_beat;

    // Decode port-level outputs from the current state
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        mem_read    = (state == ST_FETCH);
        mem_write   = (state == ST_STORE);
        mem_address = addr_q;
        load_en     = mem_read && !waitrequest;
        last_beat   = (beat == LAST);
        cmd_done    = done_q;
        carry_flag  = flag_q;
    end

    // Sequence commands and beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            beat    <= '0;
            sel_y   <= 1'b0;
            do_sub  <= 1'b0;
            carry_q <= 1'b0;
            flag_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_addr;
                        beat   <= '0;
                        case (wop_op_e'(cmd_op))
                            OP_LOAD_X: begin state <= ST_FETCH; sel_y <= 1'b0; end
                            OP_LOAD_Y: begin state <= ST_FETCH; sel_y <= 1'b1; end
                            OP_ADD: begin
                                state   <= ST_STORE;
                                do_sub  <= 1'b0;
                                carry_q <= 1'b0;
                            end
                            default: begin
                                state   <= ST_STORE;
                                do_sub  <= 1'b1;
                                carry_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (!waitrequest) begin
                        addr_q <= addr_q + STEP;
                        beat   <= beat + 1'b1;
                        if (last_beat) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_STORE: begin
                    if (!waitrequest) begin
                        addr_q  <= addr_q + STEP;
                        beat    <= beat + 1'b1;
                        carry_q <= alu_cout;
                        if (last_beat) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            flag_q <= do_sub ? ~alu_cout : alu_cout;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wop_accel.sv
`timescale 1ns/1ps
// Top of the wide-operand coprocessor. Commands arrive on a narrow port;
// operands are fetched and results stored over a memory-mapped master
// with waitrequest. Assumes read data is valid in the cycle a read is
// accepted, and that OP_W is a power-of-two multiple of BUS_W.
module wop_accel #(
    parameter int OP_W   = 1024,
    parameter int BUS_W  = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_done,
    output logic              carry_flag,
    output logic [ADDR_W-1:0] mem_address,
    output logic              mem_read,
    output logic              mem_write,
    output logic [BUS_W-1:0]  mem_writedata,
    input  logic [BUS_W-1:0]  mem_readdata,
    input  logic              mem_waitrequest
);
    localparam int BEATS = OP_W / BUS_W;
    localparam int IDX_W = $clog2(BEATS);

    logic [IDX_W-1:0] beat;
    logic             load_en, sel_y, do_sub, carry_q, alu_cout;
    logic [BUS_W-1:0] x_slice, y_slice;

    wop_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .cmd_done(cmd_done), .carry_flag(carry_flag),
        .waitrequest(mem_waitrequest), .mem_read(mem_read), .mem_write(mem_write),
        .mem_address(mem_address), .beat(beat), .load_en(load_en), .sel_y(sel_y),
        .do_sub(do_sub), .carry_q(carry_q), .alu_cout(alu_cout)
    );

    wop_operand_store #(.BUS_W(BUS_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(load_en), .wr_sel_y(sel_y),
        .idx(beat), .wr_data(mem_readdata), .x_slice(x_slice), .y_slice(y_slice)
    );

    wop_slice_alu #(.BUS_W(BUS_W)) u_alu (
        .do_sub(do_sub), .cin(carry_q), .a(x_slice), .b(y_slice),
        .sum(mem_writedata), .cout(alu_cout)
    );
endmodule

// File: rtl/wop_accel_chk.sv
`timescale 1ns/1ps
// Protocol checker for wop_accel, attached by bind. Watches only ports.
module wop_accel_chk #(
    parameter int BUS_W  = 64,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              cmd_done,
    input logic              carry_flag,
    input logic [ADDR_W-1:0] mem_address,
    input logic              mem_read,
    input logic              mem_write,
    input logic [BUS_W-1:0]  mem_writedata,
    input logic              mem_waitrequest
);
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write)); // R9
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_waitrequest) |=> (mem_read && $stable(mem_address))); // R3
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write && mem_waitrequest) |=> (mem_write && $stable(mem_address) && $stable(mem_writedata))); // R3
    AST_BUS_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(mem_read || mem_write)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R7
    AST_DONE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(mem_read || mem_write)); // R7
    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry_flag) |-> cmd_done); // R7
endmodule

bind wop_accel wop_accel_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .carry_flag(carry_flag), .mem_address(mem_address), .mem_read(mem_read),
    .mem_write(mem_write), .mem_writedata(mem_writedata),
    .mem_waitrequest(mem_waitrequest)
);

// File: tb/sim_wop_accel.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues every expected bus beat, and
// a monitor at the falling edge pops and compares accepted transfers.
module sim_wop_accel;
    localparam int OPW   = 1024;
    localparam int BW    = 64;
    localparam int AW    = 16;
    localparam int BEATS = OPW / BW;
    localparam int BYTES = BW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_done, carry_flag;
    logic [AW-1:0] mem_address;
    logic          mem_read, mem_write;
    logic [BW-1:0] mem_writedata, mem_readdata;
    logic          mem_waitrequest = 1'b0;

    always #10 clk = ~clk;

    wop_accel #(.OP_W(OPW), .BUS_W(BW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
        .carry_flag(carry_flag), .mem_address(mem_address), .mem_read(mem_read),
        .mem_write(mem_write), .mem_writedata(mem_writedata),
        .mem_readdata(mem_readdata), .mem_waitrequest(mem_waitrequest)
    );

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [BW-1:0] data;
        string         req;
    } beat_t;

    logic [BW-1:0] mem [0:255];
    beat_t         exp_q[$];
    logic [OPW-1:0] mdl_x = '0, mdl_y = '0;
    int  n_tests = 0, n_fail = 0;
    bit  stall_en = 1'b1;
    bit  prev_stall = 1'b0, prev_wr = 1'b0;
    logic [AW-1:0] prev_addr;
    logic [BW-1:0] prev_data;

    assign mem_readdata = mem[mem_address[10:3]];

    task automatic chk(input bit ok, input string req, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Monitor: drive waitrequest for the coming edge, then score the transfer
    always @(negedge clk) begin
        mem_waitrequest = stall_en ? ($urandom % 3 == 0) : 1'b0;
        if (rst_n) begin
            if (mem_read && mem_write)
                chk(1'b0, "R9", "read and write asserted together, actual 11 expected not both");
            if (prev_stall)
                chk((mem_write == prev_wr) && (mem_read == !prev_wr) && mem_address == prev_addr
                    && (!prev_wr || mem_writedata == prev_data), "R3",
                    $sformatf("stalled beat changed: actual addr %h data %h, expected addr %h data %h",
                              mem_address, mem_writedata, prev_addr, prev_data));
            prev_stall = (mem_read || mem_write) && mem_waitrequest;
            prev_wr    = mem_write;
            prev_addr  = mem_address;
            prev_data  = mem_writedata;
            if ((mem_read || mem_write) && !mem_waitrequest) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", $sformatf("unexpected transfer: actual wr=%0b addr %h, expected none",
                                              mem_write, mem_address));
                end else begin
                    beat_t it;
                    it = exp_q.pop_front();
                    chk(it.wr == mem_write && it.addr == mem_address && (!it.wr || it.data == mem_writedata),
                        it.req, $sformatf("beat: actual wr=%0b addr %h data %h, expected wr=%0b addr %h data %h",
                                          mem_write, mem_address, mem_writedata, it.wr, it.addr, it.data));
                end
                if (mem_write) mem[mem_address[10:3]] = mem_writedata;
            end
        end
    end

    // Driver: queue expected beats, present the command, wait for completion
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] addr, input string req, input bit poke);
        logic [OPW:0] full;
        bit exp_flag;
        while (!cmd_ready) @(negedge clk);
        for (int i = 0; i < BEATS; i++) begin
            beat_t it;
            it.wr   = op[1];
            it.addr = addr + AW'(i * BYTES);
            it.req  = req;
            it.data = '0;
            if (!op[1]) begin
                if (op[0]) mdl_y[i*BW +: BW] = mem[(addr >> 3) + i];
                else       mdl_x[i*BW +: BW] = mem[(addr >> 3) + i];
            end
            exp_q.push_back(it);
        end
        full = '0;
        exp_flag = 1'b0;
        if (op == 2'b10) begin
            full = {1'b0, mdl_x} + {1'b0, mdl_y};
            exp_flag = full[OPW];
        end else if (op == 2'b11) begin
            full = {1'b0, mdl_x - mdl_y};
            exp_flag = (mdl_x < mdl_y);
        end
        if (op[1])
            for (int i = 0; i < exp_q.size(); i++)
                exp_q[i].data = full[(i % BEATS)*BW +: BW];
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'b00;
                cmd_addr  = 16'h0600;
                chk(!cmd_ready, "R6", $sformatf("ready while busy: actual %0b expected 0", cmd_ready));
                @(negedge clk);
            end
            cmd_valid = 1'b0;
        end
        while (!cmd_done) @(negedge clk);
        chk(exp_q.size() == 0, req, $sformatf("beats left at done: actual %0d expected 0", exp_q.size()));
        if (op[1])
            chk(carry_flag == exp_flag, req, $sformatf("flag: actual %0b expected %0b", carry_flag, exp_flag));
        @(negedge clk);
        chk(!cmd_done && cmd_ready, "R7", $sformatf("done/ready after pulse: actual %0b/%0b expected 0/1",
                                                     cmd_done, cmd_ready));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom};
        for (int i = 0; i < BEATS; i++) begin
            mem[32 + i] = '1;
            mem[48 + i] = (i == 0) ? BW'(1) : '0;
        end
        repeat (3) @(negedge clk);
        // R1: idle state during and after reset
        chk(cmd_ready && !mem_read && !mem_write && !cmd_done && !carry_flag, "R1",
            $sformatf("reset: actual rdy=%0b rd=%0b wr=%0b done=%0b flag=%0b expected 1 0 0 0 0",
                      cmd_ready, mem_read, mem_write, cmd_done, carry_flag));
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !mem_read && !mem_write && !cmd_done && !carry_flag, "R1",
            $sformatf("after reset: actual rdy=%0b rd=%0b wr=%0b done=%0b flag=%0b expected 1 0 0 0 0",
                      cmd_ready, mem_read, mem_write, cmd_done, carry_flag));

        issue(2'b00, 16'h0000, "R2", 1'b0);       // load X random
        issue(2'b01, 16'h0080, "R2", 1'b1);       // load Y, busy commands presented (R6)
        issue(2'b10, 16'h0400, "R4", 1'b0);       // random add
        issue(2'b11, 16'h0480, "R5", 1'b1);       // random subtract with poke (R6)
        issue(2'b10, 16'h0500, "R8", 1'b0);       // reuse without reload
        issue(2'b00, 16'h0100, "R2", 1'b0);       // X = all ones
        issue(2'b01, 16'h0180, "R2", 1'b0);       // Y = 1
        issue(2'b10, 16'h0580, "R4", 1'b0);       // carry through every slice, flag 1
        issue(2'b01, 16'h0100, "R8", 1'b0);       // Y = all ones, X must persist
        issue(2'b11, 16'h0600, "R5", 1'b0);       // equal operands, flag 0
        issue(2'b00, 16'h0180, "R8", 1'b0);       // X = 1, Y persists
        issue(2'b11, 16'h0680, "R5", 1'b0);       // 1 - ones, borrow flag 1
        stall_en = 1'b0;
        issue(2'b00, 16'h0400, "R2", 1'b0);       // result reused as operand, no stalls
        issue(2'b10, 16'h0700, "R4", 1'b0);
        issue(2'b11, 16'h0780, "R5", 1'b0);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0 && cmd_ready, "R6", $sformatf("idle tail: actual %0d pending expected 0", exp_q.size()));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #3000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule